// File: doc/BRIEF.md
# Scatter-Gather Chain Walker

This block follows a table of 8-byte scatter-gather entries and turns each usable entry into one segment request for a data mover. A walk begins on a start pulse at table index 0. For each entry the block fetches two 32-bit words through a request/response port. The first word is a control word and the second word is the segment's byte address. A valid entry with a non-zero length becomes an address/length/action request. The block then waits for the mover to report that the segment is complete before it fetches the next entry.

The walk ends after the entry that carries the end-of-chain flag. If that entry also carries the ring flag, the walk continues from index 0 instead. An entry whose valid flag is clear stops the walk and raises a sticky error. There is one error flag for the read channel and one for the write channel, and the walk's channel is chosen at start. An entry can ask for an interrupt pulse once its segment completes.

All three data interfaces use valid/ready. The block holds `fetch_idx` steady while `fetch_valid` is high and `fetch_ready` is low. It holds the segment fields steady while `seg_valid` is high and `seg_ready` is low. `rsp_ready` is high only while the block waits for a response, and the responder may delay `rsp_valid` for any number of cycles. `seg_done` is a plain one-cycle pulse. It is honoured only after a segment has been accepted and before the next fetch.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset, `busy`, `fetch_valid`, `rsp_ready`, `seg_valid`, `walk_done`, `irq`, `err_rd` and `err_wr` are all 0.
- R2: A `start` pulse while idle raises `busy` in the next cycle and makes the first fetch at index 0. A `start` pulse while busy is ignored. While idle, no fetch or segment request is made.
- R3: Fetches run through consecutive indices. `fetch_idx` stays stable until it is accepted.
- R4: For a valid entry with non-zero length, one segment request is made. `seg_addr` is the entry's second word, `seg_act` is control bits 5:3, and `seg_len` comes from control bits 31:8. These fields stay stable under back-pressure, and the next fetch waits for `seg_done`.
- R5: A length above `MAX_SEG` (default 0x100000) is issued as `MAX_SEG`.
- R6: A valid entry whose length field is 0 is skipped. No segment request is made, `seg_valid` stays 0, and no interrupt is raised for it, even when control bit 2 is set.
- R7: When control bit 1 (end-of-chain) is set and bit 6 (ring) is clear, the walk ends after that entry is handled. `walk_done` pulses for one cycle, and `busy` falls in the cycle after `seg_done`, or after the response for a skipped entry.
- R8: When control bits 1 and 6 are both set, the walk goes on at index 0 without ending.
- R9: A response whose control bit 0 (valid) is 0 sets, one cycle later, `err_rd` if the walk was started with `chan_rd`=1 or `err_wr` if it was started with `chan_rd`=0. That walk ends without `walk_done`. The flag stays set until a new walk starts on the same channel. The other channel's flag is unaffected.
- R10: `irq` pulses for one cycle, in the cycle after `seg_done`, for an entry whose control bit 2 is set. It never pulses otherwise.
- R11: After index 2^`IDX_W`-1, if that entry does not end the chain, the next fetch is at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk at index 0 (ignored while busy) |
| chan_rd | input | 1 | Channel of the walk, sampled with start: 1 read, 0 write |
| busy | output | 1 | A walk is in progress |
| fetch_valid | output | 1 | Entry fetch request valid |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_idx | output | IDX_W | Table index of the requested entry |
| rsp_valid | input | 1 | Entry words valid |
| rsp_ready | output | 1 | Block waiting for entry words |
| rsp_ctrl | input | 32 | Control word of the entry |
| rsp_addr | input | 32 | Address word of the entry |
| seg_valid | output | 1 | Segment request valid |
| seg_ready | input | 1 | Segment request accepted by the mover |
| seg_addr | output | 32 | Segment byte address |
| seg_len | output | 24 | Segment length in bytes, capped at MAX_SEG |
| seg_act | output | 3 | Action code of the entry |
| seg_done | input | 1 | Mover finished the accepted segment (pulse) |
| walk_done | output | 1 | One-cycle pulse when a chain ends normally |
| irq | output | 1 | One-cycle per-entry completion interrupt |
| err_rd | output | 1 | Sticky invalid-entry error, read channel |
| err_wr | output | 1 | Sticky invalid-entry error, write channel |

## Verification
The bench builds the walker with `IDX_W`=3, so the table has eight entries. With that size, the wrap from index 7 back to 0 can be reached in a short run, and the ring case can be reached in a few dozen cycles. `MAX_SEG` keeps its default of 0x100000, so an entry with an all-ones length field exercises the cap at its real value. Pseudo-random ready and latency patterns put back-pressure on the fetch, response and segment interfaces and stretch the completion timing.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  // Control word layout
  localparam int CTRL_VALID  = 0;
  localparam int CTRL_EOC    = 1;
  localparam int CTRL_IRQ    = 2;
  localparam int CTRL_ACT_LO = 3;
  localparam int CTRL_RING   = 6;
  localparam int CTRL_LEN_LO = 8;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 24;
  localparam int ACT_W  = 3;

  localparam int N_CHAN  = 2;
  localparam int CHAN_WR = 0;
  localparam int CHAN_RD = 1;

  typedef struct packed {
    logic              valid;
    logic              eoc;
    logic              irq;
    logic              ring;
    logic              zero;
    logic [ACT_W-1:0]  act;
    logic [LEN_W-1:0]  len;
    logic [WORD_W-1:0] addr;
  } sg_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_ISSUE,
    S_ACK
  } walk_state_e;
endpackage

// File: rtl/sgw_entry_decode.sv
module sgw_entry_decode
  import sgw_pkg::*;
#(
  parameter logic [LEN_W-1:0] MAX_SEG = 24'h100000
) (
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic [WORD_W-1:0] addr_word,
  output sg_entry_t         entry
);
  logic [LEN_W-1:0] raw_len;
  logic             unused_rsv;

  assign raw_len    = ctrl_word[CTRL_LEN_LO +: LEN_W];
  assign unused_rsv = ctrl_word[7];

  always_comb begin
    entry.valid = ctrl_word[CTRL_VALID];
    entry.eoc   = ctrl_word[CTRL_EOC];
    entry.irq   = ctrl_word[CTRL_IRQ];
    entry.ring  = ctrl_word[CTRL_RING];
    entry.act   = ctrl_word[CTRL_ACT_LO +: ACT_W];
    entry.zero  = (raw_len == '0);
    entry.len   = (raw_len > MAX_SEG) ? MAX_SEG : raw_len;
    entry.addr  = addr_word;
  end
endmodule

// File: rtl/sgw_walk_fsm.sv
module sgw_walk_fsm
  import sgw_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chan_rd,
  input  logic              fetch_ready,
  input  logic              rsp_valid,
  input  logic              seg_ready,
  input  logic              seg_done,
  input  sg_entry_t         dec,
  output logic              busy,
  output logic              fetch_valid,
  output logic [IDX_W-1:0]  fetch_idx,
  output logic              rsp_ready,
  output logic              seg_valid,
  output logic [WORD_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic [ACT_W-1:0]  seg_act,
  output logic              start_evt,
  output logic              bad_evt,
  output logic              end_evt,
  output logic              irq_evt,
  output logic              walk_chan
);
  walk_state_e       state_q, state_d, state_step;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_step;
  logic              chan_q;
  logic              cur_eoc, cur_ring, cur_irq;
  logic [ACT_W-1:0]  cur_act;
  logic [LEN_W-1:0]  cur_len;
  logic [WORD_W-1:0] cur_addr;

  logic rsp_hs, ack_hs, skip_hs, step, fin_eoc, fin_ring;

  always_comb begin
    rsp_hs   = (state_q == S_WAIT) && rsp_valid;
    ack_hs   = (state_q == S_ACK) && seg_done;
    skip_hs  = rsp_hs && dec.valid && dec.zero;
    step     = skip_hs || ack_hs;
    fin_eoc  = skip_hs ? dec.eoc  : cur_eoc;
    fin_ring = skip_hs ? dec.ring : cur_ring;

    if (fin_eoc) idx_step = fin_ring ? '0 : idx_q;
    else         idx_step = idx_q + IDX_W'(1);
    state_step = (fin_eoc && !fin_ring) ? S_IDLE : S_FETCH;

    start_evt = (state_q == S_IDLE) && start;
    bad_evt   = rsp_hs && !dec.valid;
    end_evt   = step && fin_eoc && !fin_ring;
    irq_evt   = ack_hs && cur_irq;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      S_IDLE:  if (start) begin state_d = S_FETCH; idx_d = '0; end
      S_FETCH: if (fetch_ready) state_d = S_WAIT;
      S_WAIT:
        if (rsp_valid) begin
          if (!dec.valid)    state_d = S_IDLE;
          else if (dec.zero) begin state_d = state_step; idx_d = idx_step; end
          else               state_d = S_ISSUE;
        end
      S_ISSUE: if (seg_ready) state_d = S_ACK;
      S_ACK:   if (seg_done) begin state_d = state_step; idx_d = idx_step; end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      chan_q   <= 1'b0;
      cur_eoc  <= 1'b0;
      cur_ring <= 1'b0;
      cur_irq  <= 1'b0;
      cur_act  <= '0;
      cur_len  <= '0;
      cur_addr <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (start_evt) chan_q <= chan_rd;
      if (rsp_hs && dec.valid) begin
        cur_eoc  <= dec.eoc;
        cur_ring <= dec.ring;
        cur_irq  <= dec.irq;
        cur_act  <= dec.act;
        cur_len  <= dec.len;
        cur_addr <= dec.addr;
      end
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign fetch_valid = (state_q == S_FETCH);
  assign fetch_idx   = idx_q;
  assign rsp_ready   = (state_q == S_WAIT);
  assign seg_valid   = (state_q == S_ISSUE);
  assign seg_addr    = cur_addr;
  assign seg_len     = cur_len;
  assign seg_act     = cur_act;
  assign walk_chan   = chan_q;
endmodule

// File: rtl/sgw_event_flags.sv
module sgw_event_flags
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              start_chan,
  input  logic              bad_evt,
  input  logic              walk_chan,
  input  logic              end_evt,
  input  logic              irq_evt,
  output logic              walk_done,
  output logic              irq,
  output logic [N_CHAN-1:0] err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_done <= 1'b0;
      irq       <= 1'b0;
    end else begin
      walk_done <= end_evt;
      irq       <= irq_evt;
    end
  end

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan_err
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 flag_q <= 1'b0;
      else if (bad_evt && (walk_chan == 1'(c)))   flag_q <= 1'b1;
      else if (start_evt && (start_chan == 1'(c))) flag_q <= 1'b0;
    end
    assign err[c] = flag_q;
  end
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int               IDX_W   = 8,
  parameter logic [LEN_W-1:0] MAX_SEG = 24'h100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chan_rd,
  output logic              busy,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [IDX_W-1:0]  fetch_idx,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WORD_W-1:0] rsp_ctrl,
  input  logic [WORD_W-1:0] rsp_addr,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [WORD_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic [ACT_W-1:0]  seg_act,
  input  logic              seg_done,
  output logic              walk_done,
  output logic              irq,
  output logic              err_rd,
  output logic              err_wr
);
  sg_entry_t         dec;
  logic              start_evt, bad_evt, end_evt, irq_evt, walk_chan;
  logic [N_CHAN-1:0] err;

  sgw_entry_decode #(.MAX_SEG(MAX_SEG)) u_decode (
    .ctrl_word (rsp_ctrl),
    .addr_word (rsp_addr),
    .entry     (dec)
  );

  sgw_walk_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .chan_rd     (chan_rd),
    .fetch_ready (fetch_ready),
    .rsp_valid   (rsp_valid),
    .seg_ready   (seg_ready),
    .seg_done    (seg_done),
    .dec         (dec),
    .busy        (busy),
    .fetch_valid (fetch_valid),
    .fetch_idx   (fetch_idx),
    .rsp_ready   (rsp_ready),
    .seg_valid   (seg_valid),
    .seg_addr    (seg_addr),
    .seg_len     (seg_len),
    .seg_act     (seg_act),
    .start_evt   (start_evt),
    .bad_evt     (bad_evt),
    .end_evt     (end_evt),
    .irq_evt     (irq_evt),
    .walk_chan   (walk_chan)
  );

  sgw_event_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .start_chan (chan_rd),
    .bad_evt    (bad_evt),
    .walk_chan  (walk_chan),
    .end_evt    (end_evt),
    .irq_evt    (irq_evt),
    .walk_done  (walk_done),
    .irq        (irq),
    .err        (err)
  );

  assign err_rd = err[CHAN_RD];
  assign err_wr = err[CHAN_WR];
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker
  import sgw_pkg::*;
#(
  parameter int               IDX_W   = 8,
  parameter logic [LEN_W-1:0] MAX_SEG = 24'h100000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [IDX_W-1:0]  fetch_idx,
  input logic              rsp_ready,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [WORD_W-1:0] seg_addr,
  input logic [LEN_W-1:0]  seg_len,
  input logic [ACT_W-1:0]  seg_act,
  input logic              seg_done,
  input logic              walk_done,
  input logic              irq
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fetch_valid && !rsp_ready && !seg_valid));

  a_r3_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_idx)));

  a_r4_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=>
      (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_act)));

  a_r4_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && seg_valid));

  a_r5_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len <= MAX_SEG));

  a_r6_no_empty: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != '0));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> !busy);

  a_r10_irq_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(seg_done));
endmodule

bind sg_chain_walker sgw_checker #(.IDX_W(IDX_W), .MAX_SEG(MAX_SEG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .fetch_idx   (fetch_idx),
  .rsp_ready   (rsp_ready),
  .seg_valid   (seg_valid),
  .seg_ready   (seg_ready),
  .seg_addr    (seg_addr),
  .seg_len     (seg_len),
  .seg_act     (seg_act),
  .seg_done    (seg_done),
  .walk_done   (walk_done),
  .irq         (irq)
);

// File: tb/test_sg_chain_walker.sv
`timescale 1ns/1ps
module test_sg_chain_walker;
  localparam int IDX_W = 3;
  localparam int TBL   = 1 << IDX_W;
  localparam int CAP   = 'h100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, chan_rd = 1'b0;
  logic        busy, fetch_valid, rsp_ready, seg_valid, walk_done, irq, err_rd, err_wr;
  logic        fetch_ready = 1'b0, rsp_valid = 1'b0, seg_ready = 1'b0, seg_done = 1'b0;
  logic [IDX_W-1:0] fetch_idx;
  logic [31:0] rsp_ctrl = '0, rsp_addr = '0, seg_addr;
  logic [23:0] seg_len;
  logic [2:0]  seg_act;

  always #4 clk = ~clk;

  sg_chain_walker #(.IDX_W(IDX_W)) i_sg_chain_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_rd(chan_rd), .busy(busy),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_idx(fetch_idx),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ctrl(rsp_ctrl), .rsp_addr(rsp_addr),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_act(seg_act), .seg_done(seg_done), .walk_done(walk_done), .irq(irq),
    .err_rd(err_rd), .err_wr(err_wr));

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [31:0] tbl_ctrl [TBL];
  logic [31:0] tbl_addr [TBL];

  // stimulus requests from the scenario thread
  logic start_req = 1'b0, req_chan = 1'b0;

  // reference model
  logic m_busy, m_irq, m_done, m_err_rd, m_err_wr, m_segv, m_chan;
  int   m_next, m_cur_idx, n_fetch0, n_seg;
  logic seen7;
  logic [31:0] m_cur_ctrl, m_cur_addr;

  // bench-side responders
  logic rsp_pend, done_pend;
  int   rsp_idx, rsp_wait, done_wait;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] mk(input bit v, e, i, input int act, input bit r, input int len);
    return {len[23:0], 1'b0, r, act[2:0], i, e, v};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void advance(input logic [31:0] c, input int idx);
    if (c[1]) begin
      if (c[6]) m_next = 0;
      else begin m_busy = 1'b0; m_done = 1'b1; end
    end else m_next = (idx + 1) % TBL;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_irq = 0; m_done = 0; m_err_rd = 0; m_err_wr = 0; m_segv = 0;
      m_chan = 0; m_next = 0; rsp_pend = 0; done_pend = 0;
      start <= 1'b0; rsp_valid <= 1'b0; seg_done <= 1'b0; fetch_ready <= 1'b0; seg_ready <= 1'b0;
      start_req = 1'b0;
      if (cyc > 0) begin // R1 reset state
        chk("R1 busy", busy, 0);          chk("R1 fetch_valid", fetch_valid, 0);
        chk("R1 rsp_ready", rsp_ready, 0); chk("R1 seg_valid", seg_valid, 0);
        chk("R1 walk_done", walk_done, 0); chk("R1 irq", irq, 0);
        chk("R1 err_rd", err_rd, 0);      chk("R1 err_wr", err_wr, 0);
      end
      cyc++;
    end else begin
      cyc++;
      // compare every clock against the model
      chk("R2 busy", busy, m_busy);
      chk("R10 irq", irq, m_irq);
      chk("R7 walk_done", walk_done, m_done);
      chk("R9 err_rd", err_rd, m_err_rd);
      chk("R9 err_wr", err_wr, m_err_wr);
      chk("R6 seg_valid", seg_valid, m_segv);

      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      // drive inputs for the coming edge
      fetch_ready = lfsr[0] | lfsr[3];
      seg_ready   = lfsr[1] | lfsr[5];
      if (rsp_pend && rsp_wait > 0) rsp_wait--;
      rsp_valid = rsp_pend && (rsp_wait == 0);
      rsp_ctrl  = tbl_ctrl[rsp_idx];
      rsp_addr  = tbl_addr[rsp_idx];
      if (done_pend && done_wait > 0) done_wait--;
      seg_done = done_pend && (done_wait == 0);
      start    = start_req;
      chan_rd  = req_chan;
      start_req = 1'b0;

      // predict the effect of this edge
      m_irq = 0; m_done = 0;
      if (start && !m_busy) begin
        m_busy = 1; m_chan = chan_rd; m_next = 0;
        if (chan_rd) m_err_rd = 0; else m_err_wr = 0;
      end
      if (fetch_valid && fetch_ready) begin
        chk("R3 fetch_idx", 32'(fetch_idx), 32'(m_next));
        rsp_pend = 1; rsp_idx = int'(fetch_idx); rsp_wait = int'(lfsr[7:6]);
        if (fetch_idx == 0) n_fetch0++;
        if (fetch_idx == 3'd7) seen7 = 1;
      end
      if (rsp_valid && rsp_ready) begin
        rsp_pend = 0;
        if (!rsp_ctrl[0]) begin
          if (m_chan) m_err_rd = 1; else m_err_wr = 1;
          m_busy = 0;
        end else if (rsp_ctrl[31:8] == 0) advance(rsp_ctrl, rsp_idx);
        else begin
          m_segv = 1; m_cur_ctrl = rsp_ctrl; m_cur_addr = rsp_addr; m_cur_idx = rsp_idx;
        end
      end
      if (seg_valid && seg_ready) begin
        chk("R4 seg_addr", seg_addr, m_cur_addr);
        chk("R4 seg_act", 32'(seg_act), 32'(m_cur_ctrl[5:3]));
        chk("R5 seg_len", 32'(seg_len),
            (int'(m_cur_ctrl[31:8]) > CAP) ? 32'(CAP) : 32'(m_cur_ctrl[31:8]));
        done_pend = 1; done_wait = int'(lfsr[9:8]); m_segv = 0; n_seg++;
      end
      if (seg_done) begin
        done_pend = 0;
        m_irq = m_cur_ctrl[2];
        advance(m_cur_ctrl, m_cur_idx);
      end
    end
    if (cyc > 150000) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_walk(input bit ch);
    @(posedge clk); req_chan = ch; start_req = 1'b1;
    @(posedge clk);
    while (start_req || m_busy) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic do_reset;
    @(posedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    n_fetch0 = 0; n_seg = 0; seen7 = 0;
    for (int i = 0; i < TBL; i++) begin tbl_ctrl[i] = '0; tbl_addr[i] = '0; end
    do_reset();

    // basic chain on the write channel, R4 R7 R10
    tbl_ctrl[0] = mk(1,0,0,3,0,'h10);     tbl_addr[0] = 32'h1000_0000;
    tbl_ctrl[1] = mk(1,0,1,5,0,'h200);    tbl_addr[1] = 32'h2000_0040;
    tbl_ctrl[2] = mk(1,1,1,7,0,'h100000); tbl_addr[2] = 32'h3000_0800;
    n_seg = 0;
    run_walk(0);
    chk("R4 segment count", 32'(n_seg), 3);

    // cap, zero-length skips (one with irq bit), ignored start while busy: R5 R6 R2
    tbl_ctrl[0] = mk(1,0,0,1,0,'hFFFFFF); tbl_addr[0] = 32'hDEAD_0000;
    tbl_ctrl[1] = mk(1,0,1,2,0,0);        tbl_addr[1] = 32'h0;
    tbl_ctrl[2] = mk(1,1,0,0,0,0);        tbl_addr[2] = 32'h0;
    n_seg = 0;
    @(posedge clk); req_chan = 0; start_req = 1'b1;
    repeat (3) @(posedge clk);
    start_req = 1'b1;  // R2: busy, must be ignored
    @(posedge clk);
    while (start_req || m_busy) @(posedge clk);
    repeat (3) @(posedge clk);
    chk("R6 only nonzero issued", 32'(n_seg), 1);

    // invalid entry on the read channel, R9
    tbl_ctrl[0] = mk(1,0,0,0,0,'h40); tbl_addr[0] = 32'h4000_0000;
    tbl_ctrl[1] = mk(0,0,1,0,0,'h40);
    run_walk(1);
    chk("R9 err_rd set", err_rd, 1);
    chk("R9 err_wr clear", err_wr, 0);
    tbl_ctrl[1] = mk(1,1,0,4,0,'h80);  tbl_addr[1] = 32'h4000_1000;
    run_walk(0);
    chk("R9 err_rd kept over write walk", err_rd, 1);
    run_walk(1);
    chk("R9 err_rd cleared by read start", err_rd, 0);

    // ring: R8
    tbl_ctrl[0] = mk(1,0,1,6,0,'h4); tbl_addr[0] = 32'h5000_0000;
    tbl_ctrl[1] = mk(1,1,0,2,1,'h8); tbl_addr[1] = 32'h5000_0100;
    n_fetch0 = 0;
    @(posedge clk); req_chan = 0; start_req = 1'b1;
    repeat (120) @(posedge clk);
    chk("R8 still busy in ring", busy, 1);
    chk("R8 index 0 revisited", 32'(n_fetch0 >= 2), 1);
    do_reset();

    // index wrap: R11
    for (int i = 0; i < TBL; i++) begin
      tbl_ctrl[i] = mk(1,0,0,i,0,(i % 3 == 1) ? 0 : 4 + i);
      tbl_addr[i] = 32'h6000_0000 + 32'(i * 16);
    end
    n_fetch0 = 0; seen7 = 0;
    @(posedge clk); req_chan = 1; start_req = 1'b1;
    while (!seen7) @(posedge clk);
    tbl_ctrl[0] = mk(1,1,1,1,0,'h20);
    @(posedge clk);
    while (m_busy) @(posedge clk);
    repeat (3) @(posedge clk);
    chk("R11 wrapped to index 0", 32'(n_fetch0), 2);
    chk("R11 walk finished", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule